// File: doc/BRIEF.md
# Crossbar Weight Programming Sequencer

This block is the digital controller that sits beside one binary-weight crossbar subarray. Columns of the array are the input nodes of one fully connected layer and rows are its output nodes; every weight is held by a pair of resistive cells in opposite states. The sequencer has two operating modes. In configuration mode it accepts one row of weight values per handshake beat. It reduces each value to a sign, turns that sign into a complementary pair of cell write commands, and raises the write word line of that row for one cycle. A continuous stream therefore programs the whole array in as many cycles as there are rows. In inference mode it holds the static read levels: read word line high, write word lines low, source lines released, and bit lines handed over to the layer's input signals.

Software selects configuration mode, pulses start, and streams the rows in order from row 0. A one-cycle done pulse marks the end of programming. A mode request made while a programming pass is running waits until the pass has finished.

Top module: `xbar_prog_seq`

## Requirements
- R1: After reset the block is in inference mode. `rwl_o` is 1, `wwl_o` is all zero, and `row_ready_o` and `done_o` are 0.
- R2: In inference mode `rwl_o`=1, `wwl_o`=0 and `bl_pass_o`=1, and every 2-bit field of `cell_a_code_o`, `cell_b_code_o` and `sl_code_o` is 2'b11 (high-impedance).
- R3: In configuration mode, in any cycle with no row being written, `rwl_o`=0, `bl_pass_o`=0, `wwl_o`=0, and every cell and source-line field is 2'b00 (idle).
- R4: `start_i` sampled high while the block is idle in configuration mode and `cfg_mode_i` is still 1 begins a programming pass at row 0. `row_ready_o` is 1 for the whole pass.
- R5: A beat accepted on a clock edge (`row_valid_i` and `row_ready_o` both 1) drives, in the following cycle, `wwl_o` one-hot at the current row index. The index then advances by one. Without an accepted beat the index holds and `wwl_o` is 0. At most one write word line is ever high.
- R6: Column c's value is bits [c*VAL_W +: VAL_W] of `row_val_i`, read as two's complement. A value of 0 or above binarizes to +1 and a negative value to -1. For +1 the column's field [2c +: 2] is 2'b01 (write parallel) on `cell_a_code_o` and 2'b10 (write antiparallel) on `cell_b_code_o`. For -1 the two are swapped.
- R7: After the beat for row N_ROWS-1 is accepted, `row_ready_o` is 0 from the next cycle. `done_o` is 1 for exactly one cycle, the cycle that follows the one in which that last row's word line is high.
- R8: `cfg_mode_i` has no effect during a programming pass. A level it holds at the end of the pass takes effect on the first clock edge after the pass ends.
- R9: `start_i` has no effect during a programming pass, where it neither restarts nor moves the row index, and none in inference mode.
- R10: With `row_valid_i` held high, the N_ROWS rows are written in N_ROWS consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode_i | input | 1 | Requested mode: 1 configuration, 0 inference |
| start_i | input | 1 | Begins a programming pass |
| row_valid_i | input | 1 | A row of weights is present |
| row_ready_o | output | 1 | The sequencer accepts a row this cycle |
| row_val_i | input | N_COLS*VAL_W | Signed weight value per column |
| wwl_o | output | N_ROWS | One-hot write word lines |
| cell_a_code_o | output | 2*N_COLS | Drive code for the first cell of each column pair |
| cell_b_code_o | output | 2*N_COLS | Drive code for the second cell of each column pair |
| sl_code_o | output | 2*N_COLS | Source-line drive code per column |
| bl_pass_o | output | 1 | Bit lines routed to the layer input signals |
| rwl_o | output | 1 | Read word line enable |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The hardest case to reach is a mode change that arrives while a pass is running and must take effect exactly one edge after the last row. The bench drops `cfg_mode_i` partway through a pass, keeps the row stream going, and checks `rwl_o` on both sides of the final write. Idle gaps are placed at different row positions from pass to pass, and a stray start is raised in mid-stream, so that the row index is seen to hold or carry on rather than reset. A sweep over every combination of signed column values exercises both binarization outcomes in every column.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    DRV_IDLE  = 2'b00,
    DRV_WR_P  = 2'b01,
    DRV_WR_AP = 2'b10,
    DRV_HIZ   = 2'b11
  } drv_code_e;

  typedef enum logic [1:0] {
    ST_INFER = 2'b00,
    ST_CFG   = 2'b01,
    ST_PROG  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/xbar_mode_ctl.sv
module xbar_mode_ctl
  import xbar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_mode_i,
  input  logic       start_i,
  input  logic       row_accept,
  input  logic       row_last,
  output seq_state_e state_o,
  output logic       start_go,
  output logic       done_o
);
  seq_state_e state_q;
  logic       last_wr_q;
  logic       done_q;

  assign start_go = (state_q == ST_CFG) && cfg_mode_i && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INFER;
      last_wr_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_INFER: if (cfg_mode_i) state_q <= ST_CFG;
        ST_CFG: begin
          if (!cfg_mode_i)   state_q <= ST_INFER;
          else if (start_go) state_q <= ST_PROG;
        end
        ST_PROG: if (row_accept && row_last) state_q <= ST_CFG;
        default: state_q <= ST_INFER;
      endcase
      last_wr_q <= row_accept && row_last;
      done_q    <= last_wr_q;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  // R8: a running pass never falls straight back to inference
  a_r8_pass_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG) |=> (state_q != ST_INFER));
  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/xbar_row_cnt.sv
module xbar_row_cnt #(
  parameter int N_ROWS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic              row_last,
  output logic [N_ROWS-1:0] wwl_o
);
  localparam int RW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;

  logic [RW-1:0]     idx_q;
  logic [N_ROWS-1:0] wwl_q;

  function automatic logic [N_ROWS-1:0] row_onehot(input logic [RW-1:0] i);
    logic [N_ROWS-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  assign row_last = (idx_q == RW'(N_ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      wwl_q <= '0;
    end else begin
      if (clear)        idx_q <= '0;
      else if (advance) idx_q <= row_last ? '0 : idx_q + 1'b1;
      wwl_q <= advance ? row_onehot(idx_q) : '0;
    end
  end

  assign wwl_o = wwl_q;

  // R5: never more than one write word line
  a_r5_wwl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wwl_q));
  // R5: the row index moves only on an accepted beat or a new pass
  a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(idx_q));
endmodule

// File: rtl/xbar_cell_enc.sv
module xbar_cell_enc
  import xbar_pkg::*;
#(
  parameter int N_COLS = 16,
  parameter int VAL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [N_COLS*VAL_W-1:0] row_val,
  output logic [2*N_COLS-1:0]     a_codes,
  output logic [2*N_COLS-1:0]     b_codes
);
  logic [2*N_COLS-1:0] a_nxt, b_nxt, a_q, b_q;

  // deterministic binarization: negative values map to -1
  function automatic logic binarize_neg(input logic [VAL_W-1:0] v);
    return v[VAL_W-1];
  endfunction

  always_comb begin
    for (int c = 0; c < N_COLS; c++) begin
      if (!load) begin
        a_nxt[2*c +: 2] = DRV_IDLE;
        b_nxt[2*c +: 2] = DRV_IDLE;
      end else if (binarize_neg(row_val[c*VAL_W +: VAL_W])) begin
        a_nxt[2*c +: 2] = DRV_WR_AP;
        b_nxt[2*c +: 2] = DRV_WR_P;
      end else begin
        a_nxt[2*c +: 2] = DRV_WR_P;
        b_nxt[2*c +: 2] = DRV_WR_AP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_nxt;
      b_q <= b_nxt;
    end
  end

  assign a_codes = a_q;
  assign b_codes = b_q;
endmodule

// File: rtl/xbar_prog_seq.sv
module xbar_prog_seq
  import xbar_pkg::*;
#(
  parameter int N_COLS = 16,
  parameter int N_ROWS = 8,
  parameter int VAL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_mode_i,
  input  logic                    start_i,
  input  logic                    row_valid_i,
  output logic                    row_ready_o,
  input  logic [N_COLS*VAL_W-1:0] row_val_i,
  output logic [N_ROWS-1:0]       wwl_o,
  output logic [2*N_COLS-1:0]     cell_a_code_o,
  output logic [2*N_COLS-1:0]     cell_b_code_o,
  output logic [2*N_COLS-1:0]     sl_code_o,
  output logic                    bl_pass_o,
  output logic                    rwl_o,
  output logic                    done_o
);
  localparam logic [2*N_COLS-1:0] ALL_HIZ  = {N_COLS{2'(DRV_HIZ)}};
  localparam logic [2*N_COLS-1:0] ALL_IDLE = {N_COLS{2'(DRV_IDLE)}};

  seq_state_e          state;
  logic                start_go;
  logic                row_accept;
  logic                row_last;
  logic [2*N_COLS-1:0] a_wr, b_wr;

  assign row_ready_o = (state == ST_PROG);
  assign row_accept  = row_ready_o && row_valid_i;

  xbar_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i), .start_i(start_i),
    .row_accept(row_accept), .row_last(row_last),
    .state_o(state), .start_go(start_go), .done_o(done_o)
  );

  xbar_row_cnt #(.N_ROWS(N_ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .clear(start_go), .advance(row_accept),
    .row_last(row_last), .wwl_o(wwl_o)
  );

  xbar_cell_enc #(.N_COLS(N_COLS), .VAL_W(VAL_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .load(row_accept), .row_val(row_val_i),
    .a_codes(a_wr), .b_codes(b_wr)
  );

  assign rwl_o         = (state == ST_INFER);
  assign bl_pass_o     = rwl_o;
  assign cell_a_code_o = rwl_o ? ALL_HIZ : a_wr;
  assign cell_b_code_o = rwl_o ? ALL_HIZ : b_wr;
  assign sl_code_o     = rwl_o ? ALL_HIZ : ALL_IDLE;

  function automatic logic pairs_opposed(input logic [2*N_COLS-1:0] a,
                                         input logic [2*N_COLS-1:0] b);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < N_COLS; c++)
      if (!((a[2*c +: 2] == DRV_WR_P  && b[2*c +: 2] == DRV_WR_AP) ||
            (a[2*c +: 2] == DRV_WR_AP && b[2*c +: 2] == DRV_WR_P)))
        ok = 1'b0;
    return ok;
  endfunction

  // R2: reading and writing never overlap
  a_r2_read_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
    rwl_o |-> (wwl_o == '0));
  // R6: a raised word line always carries a complementary cell pair per column
  a_r6_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (|wwl_o) |-> pairs_opposed(cell_a_code_o, cell_b_code_o));
  // R3: configuration cycles with no write leave every driver idle
  a_r3_idle_drivers: assert property (@(posedge clk) disable iff (!rst_n)
    (!rwl_o && !(|wwl_o)) |-> (cell_a_code_o == '0 && cell_b_code_o == '0));
  // R7: done follows the cycle in which the last row was written
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wwl_o[N_ROWS-1]));
endmodule

// File: tb/sim_xbar_prog_seq.sv
module sim_xbar_prog_seq;
  localparam int NC = 4;
  localparam int NR = 4;
  localparam int VW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_mode_i = 1'b0, start_i = 1'b0, row_valid_i = 1'b0;
  logic [NC*VW-1:0] row_val_i = '0;
  logic             row_ready_o, bl_pass_o, rwl_o, done_o;
  logic [NR-1:0]    wwl_o;
  logic [2*NC-1:0]  cell_a_code_o, cell_b_code_o, sl_code_o;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  xbar_prog_seq #(.N_COLS(NC), .N_ROWS(NR), .VAL_W(VW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // expected first-cell code: a value at or above 2^(VW-1) is negative
  function automatic logic [2*NC-1:0] exp_a(input logic [NC*VW-1:0] v);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++)
      r[2*c +: 2] = (int'(v[c*VW +: VW]) >= (1 << (VW-1))) ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic [2*NC-1:0] exp_b(input logic [NC*VW-1:0] v);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++)
      r[2*c +: 2] = (int'(v[c*VW +: VW]) >= (1 << (VW-1))) ? 2'b01 : 2'b10;
    return r;
  endfunction

  task automatic chk_infer(input string tag);
    chk(rwl_o == 1'b1 && bl_pass_o == 1'b1, {tag, " R2 rwl/bl_pass"}, {rwl_o, bl_pass_o}, 2'b11);
    chk(wwl_o == '0, {tag, " R2 wwl"}, wwl_o, 0);
    chk(cell_a_code_o == '1 && cell_b_code_o == '1 && sl_code_o == '1,
        {tag, " R2 hiz codes"}, {cell_a_code_o, cell_b_code_o, sl_code_o}, {3*2*NC{1'b1}});
  endtask

  task automatic chk_cfg_idle(input string tag);
    chk(rwl_o == 1'b0 && bl_pass_o == 1'b0 && wwl_o == '0, {tag, " R3 lines"},
        {rwl_o, bl_pass_o, wwl_o}, 0);
    chk(cell_a_code_o == '0 && cell_b_code_o == '0 && sl_code_o == '0, {tag, " R3 codes"},
        {cell_a_code_o, cell_b_code_o, sl_code_o}, 0);
  endtask

  // one full pass; drop_mode lowers cfg_mode_i before row 1 (R8);
  // stray raises start_i during row 2 (R9)
  task automatic run_pass(input int p, input bit drop_mode, input bit stray);
    logic [NC*VW-1:0] v;
    start_i = 1'b1;
    tick;
    start_i = 1'b0;
    chk(row_ready_o == 1'b1, "R4 ready after start", row_ready_o, 1);
    for (int r = 0; r < NR; r++) begin
      if (((p + r) % 3) == 0) begin
        row_valid_i = 1'b0;
        tick;
        chk(wwl_o == '0 && row_ready_o, "R5 gap no write", wwl_o, 0);
      end
      if (drop_mode && r == 1) cfg_mode_i = 1'b0;
      start_i     = stray && (r == 2);
      v           = (NC*VW)'(p * NR + r);
      row_val_i   = v;
      row_valid_i = 1'b1;
      tick;
      start_i = 1'b0;
      chk(wwl_o == NR'(1 << r), "R5 one-hot row", wwl_o, 1 << r);
      chk(cell_a_code_o == exp_a(v), "R6 first cell", cell_a_code_o, exp_a(v));
      chk(cell_b_code_o == exp_b(v), "R6 second cell", cell_b_code_o, exp_b(v));
      chk(rwl_o == 1'b0 && done_o == 1'b0, "R8 mode held in pass", {rwl_o, done_o}, 0);
    end
    row_valid_i = 1'b0;
    chk(row_ready_o == 1'b0, "R7 ready drops", row_ready_o, 0);
    tick;
    chk(done_o == 1'b1 && wwl_o == '0, "R7 done pulse", {done_o, wwl_o}, 1 << NR);
    chk(rwl_o == drop_mode, "R8 deferred mode applied", rwl_o, drop_mode);
    tick;
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    if (drop_mode) chk_infer("after pass");
    else           chk_cfg_idle("after pass");
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #3;
    rst_n = 1'b1;
    #0.5;
    chk(rwl_o && wwl_o == '0 && !row_ready_o && !done_o, "R1 reset state",
        {rwl_o, wwl_o, row_ready_o, done_o}, 1 << (NR + 2));
    chk_infer("reset");

    // R9: start and row beats do nothing in inference mode
    start_i = 1'b1; row_valid_i = 1'b1; row_val_i = '1;
    tick;
    chk(row_ready_o == 1'b0 && wwl_o == '0, "R9 start in inference", {row_ready_o, wwl_o}, 0);
    chk_infer("R9 inference");
    start_i = 1'b0; row_valid_i = 1'b0;

    // R10: continuous stream writes rows in consecutive cycles
    cfg_mode_i = 1'b1;
    tick;
    chk_cfg_idle("enter cfg");
    start_i = 1'b1;
    tick;
    start_i = 1'b0; row_valid_i = 1'b1;
    for (int r = 0; r < NR; r++) begin
      row_val_i = (NC*VW)'(r * 5);
      tick;
      chk(wwl_o == NR'(1 << r), "R10 back-to-back row", wwl_o, 1 << r);
    end
    row_valid_i = 1'b0;
    tick;
    chk(done_o == 1'b1, "R10 done after stream", done_o, 1);
    tick;

    // sweep every column value combination
    for (int p = 0; p < (1 << (NC*VW)) / NR; p++) begin
      run_pass(p, (p % 16) == 7, (p % 5) == 2);
      if (!cfg_mode_i) begin
        cfg_mode_i = 1'b1;
        tick;
        chk_cfg_idle("R3 re-enter cfg");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule